// File: doc/BRIEF.md
# Processor Status Monitor Output Packer

This block collects a handful of per-cycle processor events and presents them on one registered 87-bit monitor bus for an external observer. The events are:

- a data-cache access address;
- exception information;
- the instruction address and condition-fail flag of each of two execution pipelines;
- data and instruction barrier execution;
- the current instruction-cache enable level.

Each group of data bits has its own valid qualifier. While that qualifier is low, the data bits of the group are forced to zero, so a stale value never looks meaningful.

The bus can be switched off, but only at reset. The enable pin is sampled on every clock edge while reset is held. Once reset is released, the captured value is frozen. A bus that came out of reset disabled keeps its reset value of zero for as long as the block runs. A bus that came out enabled is refreshed on every rising clock edge from the inputs present at that edge.

Top module: `mon_status_packer`

## Requirements
- R1: The enable input `mon_en_i` is sampled only on rising edges where `rst_n` is low. After reset is released, any change on `mon_en_i` has no effect on `mon_o` until the next reset.
- R2: When the captured enable is 0, `mon_o` never changes after reset, so it stays all zeros.
- R3: `mon_o` is all zeros on every edge where `rst_n` is low, and also at the first edge after reset is released.
- R4: `mon_o[86]` is the data-cache address valid bit. `mon_o[59:40]` carries the 20-bit address and reads zero while bit 86 is 0.
- R5: `mon_o[85]` is the exception valid bit. `mon_o[64:60]` carries the 5-bit exception code and reads zero while bit 85 is 0.
- R6: `mon_o[82]` is the pipeline-1 valid bit. `mon_o[39:20]` carries its instruction address and `mon_o[84]` carries its condition-fail flag. Both read zero while bit 82 is 0.
- R7: `mon_o[81]` is the pipeline-0 valid bit. `mon_o[19:0]` carries its instruction address and `mon_o[83]` carries its condition-fail flag. Both read zero while bit 81 is 0.
- R8: `mon_o[80]` reports a data memory or write barrier and `mon_o[79]` reports an instruction memory barrier. Each one mirrors its input as sampled at the previous rising edge, so every change of the input appears on the bus.
- R9: `mon_o[78]` follows the instruction-cache enable level: 1 means enabled at all levels, 0 means disabled. Every change of that level is exported.
- R10: Bits 77:65 of `mon_o` are reserved and always read zero.
- R11: When the bus is enabled, the value present after a rising edge is built from the inputs sampled at that edge, which gives exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_en_i | input | 1 | Bus enable, captured only during reset |
| dc_vld_i | input | 1 | Data-cache address valid |
| dc_addr_i | input | 20 | Data-cache access address |
| exc_vld_i | input | 1 | Exception information valid |
| exc_info_i | input | 5 | Exception code |
| p0_vld_i | input | 1 | Pipeline-0 contents valid |
| p0_addr_i | input | 20 | Pipeline-0 instruction address |
| p0_ccfail_i | input | 1 | Pipeline-0 condition-code fail |
| p1_vld_i | input | 1 | Pipeline-1 contents valid |
| p1_addr_i | input | 20 | Pipeline-1 instruction address |
| p1_ccfail_i | input | 1 | Pipeline-1 condition-code fail |
| dbar_i | input | 1 | Data memory or write barrier executed |
| ibar_i | input | 1 | Instruction memory barrier executed |
| icache_en_i | input | 1 | Instruction-cache enable level |
| mon_o | output | 87 | Packed monitor bus |

## Verification
The assertions check the following on every cycle:

- the reserved bits read zero;
- each data group is zeroed while its valid bit is low;
- a bus captured as disabled stays frozen;
- the reset value is zero;
- an enabled bus mirrors the barrier and cache-enable inputs one edge late.

Only the bench's scenarios can show the rest:

- that the enable is really taken from the reset window and that later toggling of the pin is ignored;
- that field contents land in the right bit positions;
- that a second reset with a different enable level re-arms the block correctly.

The reference model is compared against the bus on every cycle for each of these scenarios.

// File: rtl/mon_pkg.sv
package mon_pkg;

   // Default geometry of the monitor bus
   localparam int unsigned DEF_ADDR_W = 20;
   localparam int unsigned DEF_EXC_W  = 5;
   localparam int unsigned DEF_RSVD_W = 13;
   // Single-bit flags above the reserved gap: icache, ibar, dbar,
   // p0 valid, p1 valid, p0 ccfail, p1 ccfail, exc valid, dc valid
   localparam int unsigned FLAG_BITS  = 9;

   function automatic int unsigned mon_bus_width(input int unsigned addr_w,
                                                 input int unsigned exc_w,
                                                 input int unsigned rsvd_w);
      return 3 * addr_w + exc_w + rsvd_w + FLAG_BITS;
   endfunction

   // Bit offsets of the single-bit flags relative to the first flag bit
   typedef enum int unsigned {
      FL_ICEN  = 0,
      FL_IBAR  = 1,
      FL_DBAR  = 2,
      FL_P0V   = 3,
      FL_P1V   = 4,
      FL_P0CC  = 5,
      FL_P1CC  = 6,
      FL_EXCV  = 7,
      FL_DCV   = 8
   } mon_flag_e;

endpackage

// File: rtl/mon_en_capture.sv
module mon_en_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic en_q
);

   // The enable is transparent only while reset is held; afterwards frozen.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= en_i;
      end
   end

endmodule

// File: rtl/mon_field_gate.sv
module mon_field_gate #(
   parameter int unsigned W          = 20,
   parameter bit          ZERO_STALE = 1'b1
) (
   input  logic         vld_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] data_o
);

   if (W < 1) begin : g_bad_w
      $error("mon_field_gate: W must be at least 1");
   end

   if (ZERO_STALE) begin : g_zero
      assign data_o = vld_i ? data_i : '0;
   end else begin : g_pass
      assign data_o = data_i;
   end

endmodule

// File: rtl/mon_bus_reg.sv
module mon_bus_reg #(
   parameter int unsigned W = 87
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (upd_i) begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/mon_status_packer.sv
module mon_status_packer #(
   parameter int unsigned ADDR_W     = mon_pkg::DEF_ADDR_W,
   parameter int unsigned EXC_W      = mon_pkg::DEF_EXC_W,
   parameter int unsigned RSVD_W     = mon_pkg::DEF_RSVD_W,
   parameter bit          ZERO_STALE = 1'b1,
   localparam int unsigned BUS_W     = mon_pkg::mon_bus_width(ADDR_W, EXC_W, RSVD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mon_en_i,
   input  logic              dc_vld_i,
   input  logic [ADDR_W-1:0] dc_addr_i,
   input  logic              exc_vld_i,
   input  logic [EXC_W-1:0]  exc_info_i,
   input  logic              p0_vld_i,
   input  logic [ADDR_W-1:0] p0_addr_i,
   input  logic              p0_ccfail_i,
   input  logic              p1_vld_i,
   input  logic [ADDR_W-1:0] p1_addr_i,
   input  logic              p1_ccfail_i,
   input  logic              dbar_i,
   input  logic              ibar_i,
   input  logic              icache_en_i,
   output logic [BUS_W-1:0]  mon_o
);
   import mon_pkg::*;

   // Field layout, lowest bit first
   localparam int unsigned P0_LSB   = 0;
   localparam int unsigned P1_LSB   = P0_LSB + ADDR_W;
   localparam int unsigned DC_LSB   = P1_LSB + ADDR_W;
   localparam int unsigned EXC_LSB  = DC_LSB + ADDR_W;
   localparam int unsigned RSVD_LSB = EXC_LSB + EXC_W;
   localparam int unsigned FLAG_LSB = RSVD_LSB + RSVD_W;
   // A pipeline lane carries its address plus its condition-fail flag
   localparam int unsigned LANE_W   = ADDR_W + 1;

   if (ADDR_W < 1 || EXC_W < 1) begin : g_bad_geom
      $error("mon_status_packer: field widths must be at least 1");
   end
   if (FLAG_LSB + FLAG_BITS != BUS_W) begin : g_bad_bus
      $error("mon_status_packer: bus width does not match layout");
   end

   // Enable captured during reset
   logic en_q;

   mon_en_capture i_en (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (mon_en_i),
      .en_q  (en_q)
   );

   // Gated data of each qualified group
   logic [ADDR_W-1:0] dc_g;
   logic [EXC_W-1:0]  exc_g;
   logic [LANE_W-1:0] lane_raw [2];
   logic [LANE_W-1:0] lane_g   [2];
   logic              lane_vld [2];

   assign lane_raw[0] = {p0_ccfail_i, p0_addr_i};
   assign lane_raw[1] = {p1_ccfail_i, p1_addr_i};
   assign lane_vld[0] = p0_vld_i;
   assign lane_vld[1] = p1_vld_i;

   mon_field_gate #(.W(ADDR_W), .ZERO_STALE(ZERO_STALE)) i_gate_dc (
      .vld_i  (dc_vld_i),
      .data_i (dc_addr_i),
      .data_o (dc_g)
   );

   mon_field_gate #(.W(EXC_W), .ZERO_STALE(ZERO_STALE)) i_gate_exc (
      .vld_i  (exc_vld_i),
      .data_i (exc_info_i),
      .data_o (exc_g)
   );

   for (genvar gi = 0; gi < 2; gi++) begin : g_lane
      mon_field_gate #(.W(LANE_W), .ZERO_STALE(ZERO_STALE)) i_gate_lane (
         .vld_i  (lane_vld[gi]),
         .data_i (lane_raw[gi]),
         .data_o (lane_g[gi])
      );
   end

   // Assemble the next bus word
   logic [BUS_W-1:0] bus_d;

   always_comb begin
      bus_d = '0;
      bus_d[P0_LSB  +: ADDR_W] = lane_g[0][ADDR_W-1:0];
      bus_d[P1_LSB  +: ADDR_W] = lane_g[1][ADDR_W-1:0];
      bus_d[DC_LSB  +: ADDR_W] = dc_g;
      bus_d[EXC_LSB +: EXC_W]  = exc_g;
      bus_d[FLAG_LSB + FL_ICEN] = icache_en_i;
      bus_d[FLAG_LSB + FL_IBAR] = ibar_i;
      bus_d[FLAG_LSB + FL_DBAR] = dbar_i;
      bus_d[FLAG_LSB + FL_P0V]  = p0_vld_i;
      bus_d[FLAG_LSB + FL_P1V]  = p1_vld_i;
      bus_d[FLAG_LSB + FL_P0CC] = lane_g[0][ADDR_W];
      bus_d[FLAG_LSB + FL_P1CC] = lane_g[1][ADDR_W];
      bus_d[FLAG_LSB + FL_EXCV] = exc_vld_i;
      bus_d[FLAG_LSB + FL_DCV]  = dc_vld_i;
   end

   mon_bus_reg #(.W(BUS_W)) i_bus (
      .clk   (clk),
      .rst_n (rst_n),
      .upd_i (en_q),
      .d_i   (bus_d),
      .q_o   (mon_o)
   );

endmodule

// File: rtl/mon_status_packer_chk.sv
module mon_status_packer_chk #(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned EXC_W      = 5,
   parameter int unsigned RSVD_W     = 13,
   parameter bit          ZERO_STALE = 1'b1,
   parameter int unsigned BUS_W      = 87
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mon_en_i,
   input logic             dbar_i,
   input logic             ibar_i,
   input logic             icache_en_i,
   input logic [BUS_W-1:0] mon_o
);
   localparam int unsigned P0_LSB   = 0;
   localparam int unsigned P1_LSB   = ADDR_W;
   localparam int unsigned DC_LSB   = 2 * ADDR_W;
   localparam int unsigned EXC_LSB  = 3 * ADDR_W;
   localparam int unsigned RSVD_LSB = EXC_LSB + EXC_W;
   localparam int unsigned FL       = RSVD_LSB + RSVD_W;

   // Independent record of the enable seen during reset
   logic en_seen;
   always_ff @(posedge clk) begin
      if (!rst_n) en_seen <= mon_en_i;
   end

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> mon_o == '0);  // R3

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mon_o[RSVD_LSB +: RSVD_W] == '0);  // R10

   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_seen |=> $stable(mon_o));  // R2

   AST_ICEN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      en_seen |=> mon_o[FL] == $past(icache_en_i));  // R9

   AST_BARRIER_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      en_seen |=> mon_o[FL+2:FL+1] == $past({dbar_i, ibar_i}));  // R8

   if (ZERO_STALE) begin : g_gate_chk
      AST_DC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !mon_o[FL+8] |-> mon_o[DC_LSB +: ADDR_W] == '0);  // R4
      AST_EXC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !mon_o[FL+7] |-> mon_o[EXC_LSB +: EXC_W] == '0);  // R5
      AST_P1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !mon_o[FL+4] |-> (mon_o[P1_LSB +: ADDR_W] == '0 && !mon_o[FL+6]));  // R6
      AST_P0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !mon_o[FL+3] |-> (mon_o[P0_LSB +: ADDR_W] == '0 && !mon_o[FL+5]));  // R7
   end

endmodule

bind mon_status_packer mon_status_packer_chk #(
   .ADDR_W     (ADDR_W),
   .EXC_W      (EXC_W),
   .RSVD_W     (RSVD_W),
   .ZERO_STALE (ZERO_STALE),
   .BUS_W      (BUS_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mon_en_i    (mon_en_i),
   .dbar_i      (dbar_i),
   .ibar_i      (ibar_i),
   .icache_en_i (icache_en_i),
   .mon_o       (mon_o)
);

// File: tb/test_mon_status_packer.sv
`timescale 1ns/1ps
module test_mon_status_packer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mon_en_i = 1'b1;
   logic        dc_vld_i = 1'b0;
   logic [19:0] dc_addr_i = '0;
   logic        exc_vld_i = 1'b0;
   logic [4:0]  exc_info_i = '0;
   logic        p0_vld_i = 1'b0;
   logic [19:0] p0_addr_i = '0;
   logic        p0_ccfail_i = 1'b0;
   logic        p1_vld_i = 1'b0;
   logic [19:0] p1_addr_i = '0;
   logic        p1_ccfail_i = 1'b0;
   logic        dbar_i = 1'b0;
   logic        ibar_i = 1'b0;
   logic        icache_en_i = 1'b0;
   logic [86:0] mon_o;

   always #2 clk = ~clk;  // 250 MHz

   mon_status_packer i_mon_status_packer (
      .clk         (clk),
      .rst_n       (rst_n),
      .mon_en_i    (mon_en_i),
      .dc_vld_i    (dc_vld_i),
      .dc_addr_i   (dc_addr_i),
      .exc_vld_i   (exc_vld_i),
      .exc_info_i  (exc_info_i),
      .p0_vld_i    (p0_vld_i),
      .p0_addr_i   (p0_addr_i),
      .p0_ccfail_i (p0_ccfail_i),
      .p1_vld_i    (p1_vld_i),
      .p1_addr_i   (p1_addr_i),
      .p1_ccfail_i (p1_ccfail_i),
      .dbar_i      (dbar_i),
      .ibar_i      (ibar_i),
      .icache_en_i (icache_en_i),
      .mon_o       (mon_o)
   );

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Behavioural reference model
   bit          mdl_en  = 1'b0;
   bit          mdl_rst = 1'b1;
   logic [86:0] exp_bus = '0;

   function automatic logic [86:0] build_word();
      logic [86:0] w = '0;
      w[86] = dc_vld_i;
      w[85] = exc_vld_i;
      w[84] = p1_vld_i & p1_ccfail_i;
      w[83] = p0_vld_i & p0_ccfail_i;
      w[82] = p1_vld_i;
      w[81] = p0_vld_i;
      w[80] = dbar_i;
      w[79] = ibar_i;
      w[78] = icache_en_i;
      if (exc_vld_i) w[64:60] = exc_info_i;
      if (dc_vld_i)  w[59:40] = dc_addr_i;
      if (p1_vld_i)  w[39:20] = p1_addr_i;
      if (p0_vld_i)  w[19:0]  = p0_addr_i;
      return w;
   endfunction

   always @(posedge clk) begin
      mdl_rst = !rst_n;
      if (!rst_n) begin
         mdl_en  = mon_en_i;
         exp_bus = '0;
      end else if (mdl_en) begin
         exp_bus = build_word();
      end
   end

   function automatic string req_of(logic [86:0] d);
      if (mdl_rst)                       return "R3";
      if (!mdl_en)                       return "R2/R1";
      if (d[77:65] != 0)                 return "R10";
      if (d[86] || d[59:40] != 0)        return "R4";
      if (d[85] || d[64:60] != 0)        return "R5";
      if (d[84] || d[82] || d[39:20] != 0) return "R6";
      if (d[83] || d[81] || d[19:0] != 0)  return "R7";
      if (d[80] || d[79])                return "R8";
      if (d[78])                         return "R9";
      return "R11";
   endfunction

   // Compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         n_vec++;
         if (mon_o !== exp_bus) begin
            n_fail++;
            $display("FAIL %s: mon_o=%h expected=%h", req_of(mon_o ^ exp_bus),
                     mon_o, exp_bus);
         end
      end
   end

   task automatic clr_inputs();
      {dc_vld_i, exc_vld_i, p0_vld_i, p1_vld_i} = '0;
      {p0_ccfail_i, p1_ccfail_i, dbar_i, ibar_i} = '0;
      dc_addr_i = '0; exc_info_i = '0; p0_addr_i = '0; p1_addr_i = '0;
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic do_reset(input bit en);
      rst_n = 1'b0;
      mon_en_i = en;
      repeat (3) step();
      rst_n = 1'b1;
   endtask

   task automatic rand_inputs(input bit toggle_en);
      dc_vld_i    = $urandom_range(0, 1);
      dc_addr_i   = 20'($urandom);
      exc_vld_i   = $urandom_range(0, 1);
      exc_info_i  = 5'($urandom);
      p0_vld_i    = $urandom_range(0, 1);
      p0_addr_i   = 20'($urandom);
      p0_ccfail_i = $urandom_range(0, 1);
      p1_vld_i    = $urandom_range(0, 1);
      p1_addr_i   = 20'($urandom);
      p1_ccfail_i = $urandom_range(0, 1);
      dbar_i      = $urandom_range(0, 1);
      ibar_i      = $urandom_range(0, 1);
      icache_en_i = $urandom_range(0, 1);
      if (toggle_en) mon_en_i = $urandom_range(0, 1);  // R1: must be ignored
   endtask

   initial begin
      // Phase A: enabled at reset; R3 zero through reset
      do_reset(1'b1);
      step();
      // R4..R7: every field fully set, then each valid dropped with data kept
      dc_vld_i = 1; dc_addr_i = 20'hFFFFF; exc_vld_i = 1; exc_info_i = 5'h1F;
      p0_vld_i = 1; p0_addr_i = 20'hFFFFF; p0_ccfail_i = 1;
      p1_vld_i = 1; p1_addr_i = 20'hFFFFF; p1_ccfail_i = 1;
      step();
      dc_vld_i = 0; step();
      exc_vld_i = 0; step();
      p1_vld_i = 0; step();
      p0_vld_i = 0; step();
      clr_inputs();
      // R8: single-cycle barrier pulses; R9: cache enable toggles
      dbar_i = 1; step(); dbar_i = 0; step();
      ibar_i = 1; step(); ibar_i = 0; step();
      icache_en_i = 1; step(); step(); icache_en_i = 0; step();
      // R11 and R1: random traffic with the enable pin toggling freely
      for (int i = 0; i < 400; i++) begin
         rand_inputs(1'b1);
         step();
      end
      clr_inputs();

      // Phase B: disabled at reset, pin raised afterwards (R1, R2)
      do_reset(1'b0);
      mon_en_i = 1'b1;
      for (int i = 0; i < 300; i++) begin
         rand_inputs(1'b0);
         step();
      end

      // Phase C: re-armed by a second reset (R1)
      do_reset(1'b1);
      mon_en_i = 1'b0;
      for (int i = 0; i < 300; i++) begin
         rand_inputs(1'b0);
         step();
      end
      @(negedge clk); #1;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule